// File: doc/BRIEF.md
# Operand Address Decoder

This block reads the addressing bytes of one instruction operand, one byte per cycle, starting at the ModRM byte. A mode input, sampled with that first byte, selects the narrow (16-bit) or wide (32-bit) address-size encoding. The block decides from the ModRM byte whether a SIB byte follows and how many displacement bytes follow, and takes exactly that many further bytes.

Base and index values come from an eight-entry register-file read port on the block's edge. There are two select outputs and two data inputs, and the read is combinational. Once the last byte has been taken, the block presents one result for a single cycle. The result is either a register operand number or an effective address, together with the ModRM reg field and the total number of bytes used.

Register numbering used throughout: AX/EAX=0, CX=1, DX=2, BX=3, SP/ESP=4, BP/EBP=5, SI=6, DI=7.

Top module: `ea_decoder`

## Requirements
- R1: The ModRM byte is split into mod (bits 7:6), reg (bits 5:3) and r/m (bits 2:0). The reg field appears unchanged on `res_reg_field_o` with the result.
- R2: With mod=11 the operand is a register. No further byte is taken, `res_is_reg_o`=1, `res_reg_num_o` is the r/m value, `res_ea_o` is 0 and `res_len_o` is 1.
- R3: In narrow mode no SIB byte is ever taken. The r/m codes 0 to 7 give BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX. mod=00 with r/m=110 instead gives a direct 16-bit displacement with no register term.
- R4: In narrow mode, mod=01 adds one sign-extended displacement byte and mod=10 adds a 16-bit little-endian displacement. Only the low 16 bits of the register values take part, the sum wraps modulo 2^16, and `res_ea_o[31:16]` is 0.
- R5: In wide mode, a memory operand with r/m=100 is followed by a SIB byte, and `res_len_o` counts that byte.
- R6: In wide mode, mod=01 takes one sign-extended displacement byte and mod=10 takes four bytes, little-endian. mod=00 with r/m=101 means a 32-bit displacement with no base. Any other r/m value names the base register. A two-byte displacement never occurs.
- R7: The SIB byte holds scale (bits 7:6), index (bits 5:3) and base (bits 2:0). The index register is shifted left by scale before it is added, and index code 100 means there is no index term. Any of the eight registers can be the base.
- R8: A SIB byte under mod=00 with base code 101 means no base register and a 32-bit displacement.
- R9: In wide mode the address is base + scaled index + displacement, modulo 2^32.
- R10: The result is valid for exactly one cycle, beginning in the cycle after the edge that takes the last byte. `in_ready_o` is low in that cycle, and `res_len_o` equals 1 + SIB byte + displacement bytes.
- R11: After reset, `in_ready_o` is 1 and `res_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| addr32_i | input | 1 | 1 selects the wide address encoding, 0 the narrow one; sampled with the ModRM byte |
| in_valid_i | input | 1 | An instruction byte is offered |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | The block takes the offered byte at this edge |
| rf_base_sel_o | output | 3 | Register-file read select for the base |
| rf_base_data_i | input | ADDR_W | Register value for the base select |
| rf_index_sel_o | output | 3 | Register-file read select for the index |
| rf_index_data_i | input | ADDR_W | Register value for the index select |
| res_valid_o | output | 1 | The result is valid in this cycle |
| res_is_reg_o | output | 1 | The operand is a register |
| res_reg_num_o | output | 3 | Register operand number (r/m field) |
| res_reg_field_o | output | 3 | ModRM reg field |
| res_ea_o | output | ADDR_W | Effective address |
| res_len_o | output | 3 | Total bytes consumed |

## Verification
Two things can happen in the same cycle: the result is presented, and the next instruction's ModRM byte is already being offered. The bench keeps `in_valid_i` high across operands, so every result cycle meets a waiting byte. In that cycle it checks that `in_ready_o` is low, that the result is correct, and that the waiting byte is taken intact in the next cycle; a byte lost or taken twice shows up as a wrong result in the operand that follows. Some operands are instead preceded by idle gaps, where the bench checks that no stray result appears.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int EA_RIDX_W = 3;
  localparam int EA_DLEN_W = 3;

  localparam logic [1:0] EA_MOD_NODISP = 2'b00;
  localparam logic [1:0] EA_MOD_DISP8  = 2'b01;
  localparam logic [1:0] EA_MOD_DISPW  = 2'b10;
  localparam logic [1:0] EA_MOD_REG    = 2'b11;

  localparam logic [2:0] EA_RM_ESCAPE  = 3'b100;
  localparam logic [2:0] EA_RM_NOBASE  = 3'b101;
  localparam logic [2:0] EA_RM_DIRECT  = 3'b110;

  localparam logic [2:0] EA_R_BX = 3'd3;
  localparam logic [2:0] EA_R_BP = 3'd5;
  localparam logic [2:0] EA_R_SI = 3'd6;
  localparam logic [2:0] EA_R_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_MODRM  = 2'd0,
    ST_SIB    = 2'd1,
    ST_DISP   = 2'd2,
    ST_RESULT = 2'd3
  } ea_state_e;

  typedef struct packed {
    logic                 use_base;
    logic [EA_RIDX_W-1:0] base;
    logic                 use_idx;
    logic [EA_RIDX_W-1:0] idx;
    logic [1:0]           scale;
  } ea_terms_t;

endpackage

// File: rtl/ea_modrm_dec.sv
module ea_modrm_dec
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 addr32_i,
  input  logic [1:0]           mod_i,
  input  logic [2:0]           rm_i,
  output ea_terms_t            terms_o,
  output logic                 is_reg_o,
  output logic                 sib_o,
  output logic [EA_DLEN_W-1:0] disp_len_o
);

  localparam logic [EA_DLEN_W-1:0] WIDE_LEN   = EA_DLEN_W'(ADDR_W / 8);
  localparam logic [EA_DLEN_W-1:0] NARROW_LEN = EA_DLEN_W'(2);

  always_comb begin
    terms_o    = '0;
    is_reg_o   = (mod_i == EA_MOD_REG);
    sib_o      = 1'b0;
    disp_len_o = '0;
    if (addr32_i) begin
      sib_o            = !is_reg_o && (rm_i == EA_RM_ESCAPE);
      terms_o.use_base = !((mod_i == EA_MOD_NODISP) && (rm_i == EA_RM_NOBASE));
      terms_o.base     = rm_i;
      unique case (mod_i)
        EA_MOD_DISP8:  disp_len_o = EA_DLEN_W'(1);
        EA_MOD_DISPW:  disp_len_o = WIDE_LEN;
        EA_MOD_NODISP: disp_len_o = terms_o.use_base ? '0 : WIDE_LEN;
        default:       disp_len_o = '0;
      endcase
    end else begin
      terms_o.use_base = 1'b1;
      terms_o.use_idx  = 1'b1;
      unique case (rm_i)
        3'd0: begin terms_o.base = EA_R_BX; terms_o.idx = EA_R_SI; end
        3'd1: begin terms_o.base = EA_R_BX; terms_o.idx = EA_R_DI; end
        3'd2: begin terms_o.base = EA_R_BP; terms_o.idx = EA_R_SI; end
        3'd3: begin terms_o.base = EA_R_BP; terms_o.idx = EA_R_DI; end
        3'd4: begin terms_o.base = EA_R_SI; terms_o.use_idx = 1'b0; end
        3'd5: begin terms_o.base = EA_R_DI; terms_o.use_idx = 1'b0; end
        3'd6: begin terms_o.base = EA_R_BP; terms_o.use_idx = 1'b0; end
        default: begin terms_o.base = EA_R_BX; terms_o.use_idx = 1'b0; end
      endcase
      if ((mod_i == EA_MOD_NODISP) && (rm_i == EA_RM_DIRECT)) begin
        terms_o.use_base = 1'b0;
      end
      unique case (mod_i)
        EA_MOD_DISP8:  disp_len_o = EA_DLEN_W'(1);
        EA_MOD_DISPW:  disp_len_o = NARROW_LEN;
        EA_MOD_NODISP: disp_len_o = terms_o.use_base ? '0 : NARROW_LEN;
        default:       disp_len_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/ea_sib_dec.sv
module ea_sib_dec
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]           mod_i,
  input  logic [7:0]           sib_i,
  output ea_terms_t            terms_o,
  output logic [EA_DLEN_W-1:0] disp_len_o
);

  localparam logic [EA_DLEN_W-1:0] WIDE_LEN = EA_DLEN_W'(ADDR_W / 8);

  always_comb begin
    terms_o.scale    = sib_i[7:6];
    terms_o.idx      = sib_i[5:3];
    terms_o.base     = sib_i[2:0];
    terms_o.use_idx  = (sib_i[5:3] != EA_RM_ESCAPE);
    terms_o.use_base = !((mod_i == EA_MOD_NODISP) && (sib_i[2:0] == EA_RM_NOBASE));
    unique case (mod_i)
      EA_MOD_DISP8: disp_len_o = EA_DLEN_W'(1);
      EA_MOD_DISPW: disp_len_o = WIDE_LEN;
      default:      disp_len_o = terms_o.use_base ? '0 : WIDE_LEN;
    endcase
  end

endmodule

// File: rtl/ea_agu.sv
module ea_agu
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 addr32_i,
  input  ea_terms_t            terms_i,
  input  logic [ADDR_W-1:0]    base_val_i,
  input  logic [ADDR_W-1:0]    idx_val_i,
  input  logic [ADDR_W-1:0]    disp_i,
  input  logic [EA_DLEN_W-1:0] disp_len_i,
  output logic [ADDR_W-1:0]    ea_o
);

  localparam int NARROW_W = 16;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] sum;

  always_comb begin
    disp_ext  = (disp_len_i == EA_DLEN_W'(1)) ?
                {{(ADDR_W-8){disp_i[7]}}, disp_i[7:0]} : disp_i;
    base_term = terms_i.use_base ? base_val_i : '0;
    idx_term  = terms_i.use_idx ? (idx_val_i << terms_i.scale) : '0;
    sum       = base_term + idx_term + disp_ext;
    ea_o      = addr32_i ? sum : {{(ADDR_W-NARROW_W){1'b0}}, sum[NARROW_W-1:0]};
  end

endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr32_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_byte_i,
  output logic              in_ready_o,
  output logic [2:0]        rf_base_sel_o,
  input  logic [ADDR_W-1:0] rf_base_data_i,
  output logic [2:0]        rf_index_sel_o,
  input  logic [ADDR_W-1:0] rf_index_data_i,
  output logic              res_valid_o,
  output logic              res_is_reg_o,
  output logic [2:0]        res_reg_num_o,
  output logic [2:0]        res_reg_field_o,
  output logic [ADDR_W-1:0] res_ea_o,
  output logic [2:0]        res_len_o
);

  localparam int DISP_BYTES = ADDR_W / 8;

  ea_state_e            state_q, state_d;
  logic                 ld_modrm, ld_sib, ld_disp;
  logic [EA_DLEN_W-1:0] cnt_q, cnt_d;

  logic                 mode32_q;
  logic [1:0]           mod_q;
  logic [2:0]           reg_q;
  logic [2:0]           rm_q;
  logic                 sib_q;
  ea_terms_t            terms_q;
  logic [EA_DLEN_W-1:0] dlen_q;
  logic [7:0]           disp_q [DISP_BYTES];
  logic [ADDR_W-1:0]    disp_flat;

  ea_terms_t            m_terms, s_terms;
  logic                 m_is_reg, m_sib;
  logic [EA_DLEN_W-1:0] m_dlen, s_dlen;
  logic [ADDR_W-1:0]    agu_ea;

  ea_modrm_dec #(.ADDR_W(ADDR_W)) u_modrm_dec (
    .addr32_i  (addr32_i),
    .mod_i     (in_byte_i[7:6]),
    .rm_i      (in_byte_i[2:0]),
    .terms_o   (m_terms),
    .is_reg_o  (m_is_reg),
    .sib_o     (m_sib),
    .disp_len_o(m_dlen)
  );

  ea_sib_dec #(.ADDR_W(ADDR_W)) u_sib_dec (
    .mod_i     (mod_q),
    .sib_i     (in_byte_i),
    .terms_o   (s_terms),
    .disp_len_o(s_dlen)
  );

  // Next-state and load enables
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ld_modrm = 1'b0;
    ld_sib   = 1'b0;
    ld_disp  = 1'b0;
    unique case (state_q)
      ST_MODRM: begin
        if (in_valid_i) begin
          ld_modrm = 1'b1;
          cnt_d    = '0;
          if (m_is_reg)            state_d = ST_RESULT;
          else if (m_sib)          state_d = ST_SIB;
          else if (m_dlen != '0)   state_d = ST_DISP;
          else                     state_d = ST_RESULT;
        end
      end
      ST_SIB: begin
        if (in_valid_i) begin
          ld_sib  = 1'b1;
          state_d = (s_dlen != '0) ? ST_DISP : ST_RESULT;
        end
      end
      ST_DISP: begin
        if (in_valid_i) begin
          ld_disp = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_d == dlen_q) state_d = ST_RESULT;
        end
      end
      default: state_d = ST_MODRM;
    endcase
  end

  // Control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MODRM;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Operand fields, loaded with enables
  always_ff @(posedge clk_i) begin
    if (ld_modrm) begin
      mode32_q <= addr32_i;
      mod_q    <= in_byte_i[7:6];
      reg_q    <= in_byte_i[5:3];
      rm_q     <= in_byte_i[2:0];
      sib_q    <= m_sib;
      terms_q  <= m_terms;
      dlen_q   <= m_dlen;
    end else if (ld_sib) begin
      terms_q  <= s_terms;
      dlen_q   <= s_dlen;
    end
  end

  // Displacement byte lanes, little-endian
  for (genvar k = 0; k < DISP_BYTES; k++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (ld_modrm) begin
        disp_q[k] <= '0;
      end else if (ld_disp && (cnt_q == EA_DLEN_W'(k))) begin
        disp_q[k] <= in_byte_i;
      end
    end
    assign disp_flat[8*k +: 8] = disp_q[k];
  end

  assign rf_base_sel_o  = terms_q.base;
  assign rf_index_sel_o = terms_q.idx;

  ea_agu #(.ADDR_W(ADDR_W)) u_agu (
    .addr32_i  (mode32_q),
    .terms_i   (terms_q),
    .base_val_i(rf_base_data_i),
    .idx_val_i (rf_index_data_i),
    .disp_i    (disp_flat),
    .disp_len_i(dlen_q),
    .ea_o      (agu_ea)
  );

  assign in_ready_o      = (state_q != ST_RESULT);
  assign res_valid_o     = (state_q == ST_RESULT);
  assign res_is_reg_o    = (mod_q == EA_MOD_REG);
  assign res_reg_num_o   = rm_q;
  assign res_reg_field_o = reg_q;
  assign res_ea_o        = res_is_reg_o ? '0 : agu_ea;
  assign res_len_o       = 3'd1 + {2'b00, sib_q} + dlen_q;

endmodule

// File: rtl/ea_decoder_chk.sv
module ea_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready,
  input logic              valid,
  input logic              is_reg,
  input logic [ADDR_W-1:0] ea,
  input logic [2:0]        len,
  input logic              mode32
);

  AST_RESULT_STALLS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> !ready);                                                  // R10

  AST_RESULT_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |=> !valid);                                                  // R10

  AST_REG_OPERAND_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && is_reg) |-> ((ea == '0) && (len == 3'd1)));               // R2

  AST_NARROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !mode32) |-> (ea[ADDR_W-1:16] == '0));                    // R4

  AST_NARROW_NO_SIB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && !mode32) |-> (len <= 3'd3));                              // R3

  AST_WIDE_NO_DISP16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid && mode32) |-> (len != 3'd4));                               // R6

endmodule

bind ea_decoder ea_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .ready (in_ready_o),
  .valid (res_valid_o),
  .is_reg(res_is_reg_o),
  .ea    (res_ea_o),
  .len   (res_len_o),
  .mode32(mode32_q)
);

// File: tb/ea_decoder_bench.sv
module ea_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr32;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic [2:0]  base_sel, index_sel;
  logic [31:0] base_data, index_data;
  logic        res_valid, res_is_reg;
  logic [2:0]  res_reg_num, res_reg_field, res_len;
  logic [31:0] res_ea;

  logic [31:0] regs [8];
  int tests = 0;
  int fails = 0;
  int case_no = 0;

  always #10 clk = ~clk;

  assign base_data  = regs[base_sel];
  assign index_data = regs[index_sel];

  ea_decoder u_ea_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr32_i(addr32),
    .in_valid_i(in_valid), .in_byte_i(in_byte), .in_ready_o(in_ready),
    .rf_base_sel_o(base_sel), .rf_base_data_i(base_data),
    .rf_index_sel_o(index_sel), .rf_index_data_i(index_data),
    .res_valid_o(res_valid), .res_is_reg_o(res_is_reg),
    .res_reg_num_o(res_reg_num), .res_reg_field_o(res_reg_field),
    .res_ea_o(res_ea), .res_len_o(res_len)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (case %0d): actual %h expected %h", tag, what, case_no, act, exp);
    end
  endtask

  // Offer a byte at a falling edge; return at the falling edge after it is taken.
  task automatic present(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(input bit m32, input logic [1:0] md, input logic [2:0] rf,
                          input logic [2:0] rm, input logic [7:0] sib);
    logic [7:0]  db [4];
    logic [31:0] disp, base, idx, ea;
    int          dlen;
    bit          has_sib, isreg;
    string       tag, ltag;
    for (int k = 0; k < 4; k++) db[k] = 8'(case_no * 37 + k * 91 + 13);
    isreg = (md == 2'b11);
    has_sib = 1'b0;
    dlen = 0; base = 0; idx = 0;
    tag = "R2";
    if (!isreg && !m32) begin
      case (rm)
        3'd0: begin base = regs[3]; idx = regs[6]; end
        3'd1: begin base = regs[3]; idx = regs[7]; end
        3'd2: begin base = regs[5]; idx = regs[6]; end
        3'd3: begin base = regs[5]; idx = regs[7]; end
        3'd4: base = regs[6];
        3'd5: base = regs[7];
        3'd6: base = (md == 2'b00) ? 32'd0 : regs[5];
        default: base = regs[3];
      endcase
      dlen = (md == 2'b01) ? 1 : (md == 2'b10) ? 2 : (rm == 3'd6) ? 2 : 0;
      tag = (md == 2'b00 && rm == 3'd6) ? "R3" : (md == 2'b00) ? "R3" : "R4";
    end else if (!isreg) begin
      if (rm == 3'd4) begin
        has_sib = 1'b1;
        idx  = (sib[5:3] == 3'd4) ? 32'd0 : (regs[sib[5:3]] << sib[7:6]);
        base = (md == 2'b00 && sib[2:0] == 3'd5) ? 32'd0 : regs[sib[2:0]];
        dlen = (md == 2'b01) ? 1 : (md == 2'b10) ? 4 : (sib[2:0] == 3'd5) ? 4 : 0;
        tag  = (md == 2'b00 && sib[2:0] == 3'd5) ? "R8" : "R7";
      end else begin
        base = (md == 2'b00 && rm == 3'd5) ? 32'd0 : regs[rm];
        dlen = (md == 2'b01) ? 1 : (md == 2'b10) ? 4 : (rm == 3'd5) ? 4 : 0;
        tag  = (md == 2'b00 && rm != 3'd5) ? "R9" : "R6";
      end
    end
    disp = 32'd0;
    if (dlen == 1) disp = {{24{db[0][7]}}, db[0]};
    else if (dlen == 2) disp = {16'd0, db[1], db[0]};
    else if (dlen == 4) disp = {db[3], db[2], db[1], db[0]};
    ea = isreg ? 32'd0 : (base + idx + disp);
    if (!m32) ea = {16'd0, ea[15:0]};
    ltag = has_sib ? "R5" : "R10";

    addr32 = m32;
    present({md, rf, rm});
    if (has_sib) present(sib);
    for (int k = 0; k < dlen; k++) present(db[k]);

    chk("R10", "result valid", {31'd0, res_valid}, 32'd1);
    chk("R10", "ready low with result", {31'd0, in_ready}, 32'd0);
    chk("R1", "reg field", {29'd0, res_reg_field}, {29'd0, rf});
    chk(ltag, "byte count", {29'd0, res_len}, 32'(1 + int'(has_sib) + dlen));
    chk(tag, "effective address", res_ea, ea);
    if (isreg) begin
      chk("R2", "register flag", {31'd0, res_is_reg}, 32'd1);
      chk("R2", "register number", {29'd0, res_reg_num}, {29'd0, rm});
    end else begin
      chk(tag, "register flag", {31'd0, res_is_reg}, 32'd0);
    end
    case_no++;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; addr32 = 1'b0;
    for (int i = 0; i < 8; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", {31'd0, in_ready}, 32'd1);
    chk("R11", "no result after reset", {31'd0, res_valid}, 32'd0);

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 8; i++) regs[i] = 32'h9E37_79B9 * 32'(i + 1 + pass * 8);
      for (int m = 0; m < 2; m++) begin
        for (int md = 0; md < 4; md++) begin
          for (int rm = 0; rm < 8; rm++) begin
            int nsib;
            nsib = (m == 1 && rm == 4 && md != 3) ? 256 : 1;
            for (int s = 0; s < nsib; s++) begin
              if (case_no % 5 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                chk("R10", "no result while idle", {31'd0, res_valid}, 32'd0);
              end
              run_case(m[0], 2'(md), 3'(rm + md + pass), 3'(rm), 8'(s));
            end
          end
        end
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10", "result drops after one cycle", {31'd0, res_valid}, 32'd0);
    summary();
    $finish;
  end

endmodule